// File: doc/BRIEF.md
# Tapped Delay-Line Convolver

The block convolves a stream of signed real samples with a fixed set of M signed coefficients and returns one full-precision result for every accepted sample. Each sample that arrives with its valid strobe is shifted into a delay line of M words. All M words are visible in parallel. Each word is multiplied by its own coefficient, and the M products are reduced by a tree of registered three-input adders. A level with P operands is padded with zeros up to a multiple of three and yields ceil(P/3) partial sums.

Complex data is handled by two instances, one for the real stream and one for the imaginary stream. The coefficients come in as one packed parameter. Coefficient k occupies bits [k*CW +: CW] and weights the sample accepted k strobes before the newest one.

A synchronous clear empties the sample history and the whole pipeline. The block never stalls: when no sample arrives, the delay line keeps its contents and the tree simply recomputes the same sum.

Top module: `tdl_conv`

## Requirements
- R1: For every accepted sample x[n], out_data equals the sum over k = 0..M-1 of coef[k]*x[n-k]. Here x[n-k] is the sample accepted k strobes earlier, and it counts as 0 if it was accepted before the last clear or never arrived.
- R2: When in_vld is high on a rising edge E and clr is low, out_vld is high for exactly the one cycle that follows edge E+ceil(log3 M)+1, which is E+3 for the default M=7. out_vld is never high at any other time.
- R3: Cycles with in_vld low do not shift the delay line. With gaps between samples, results are the same as for the same samples sent back to back.
- R4: clr high on a rising edge empties the sample history and the pipeline. In the cycle after that edge, out_vld is 0 and out_data is 0. Until a new sample is accepted, out_data stays 0, and later results see no sample from before the clear.
- R5: out_data is DW+CW+ceil(log2 M) bits wide, signed two's complement. It is exact for all input and coefficient values, including the most negative codes.
- R6: A single sample of value 1 followed by zero-valued samples produces the coefficients in order: coef[0], coef[1], and so on up to coef[M-1], then 0.
- R7: Once ceil(log3 M)+2 edges have passed with no accepted sample and no clear, out_data holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| clr | input | 1 | Synchronous clear of history and pipeline, active high |
| in_vld | input | 1 | Sample strobe |
| in_data | input | DW | Signed input sample |
| out_vld | output | 1 | Result strobe |
| out_data | output | DW+CW+ceil(log2 M) | Signed full-precision result |

## Verification
If a delay-line word is held or shifted wrongly, or if one operand in the tree is dropped or duplicated, the error shows on the very next valid result, ceil(log3 M)+2 edges after the sample that exposed it. A bench that compares every valid result therefore localizes such a fault to a single sample. A valid pipeline that is one stage too long or too short moves every out_vld pulse, so the strobe check catches it on the first sample. A clear that misses one register leaves a non-zero out_data in the cycle after the clear, or leaves stale history in the first results that follow it. Idle stretches show whether the tree settles to a fixed value, or whether a register keeps toggling when nothing has arrived.

// File: rtl/tdl_conv.sv
module tdl_conv #(
  parameter int DW = 10,
  parameter int CW = 8,
  parameter int M  = 7,
  parameter logic [M*CW-1:0] COEFS = 56'hFE017F8007FB03,
  localparam int OW = DW + CW + $clog2(M)
) (
  input  logic                 clk,
  input  logic                 clr,
  input  logic                 in_vld,
  input  logic [DW-1:0]        in_data,
  output logic                 out_vld,
  output logic signed [OW-1:0] out_data
);

  function automatic int tree_levels(input int n);
    int c;
    int l;
    c = n;
    l = 0;
    while (c > 1) begin
      c = (c + 2) / 3;
      l++;
    end
    return l;
  endfunction

  function automatic int width_at(input int n, input int lvl);
    int c;
    c = n;
    for (int i = 0; i < lvl; i++) c = (c + 2) / 3;
    return c;
  endfunction

  function automatic logic signed [OW-1:0] mulx(input logic signed [DW-1:0] x,
                                                input logic signed [CW-1:0] c);
    logic signed [OW-1:0] xe;
    logic signed [OW-1:0] ce;
    xe = OW'(x);
    ce = OW'(c);
    return xe * ce;
  endfunction

  localparam int LV  = tree_levels(M);
  localparam int LAT = LV + 2;

  logic [M-1:0][DW-1:0]   taps;
  logic signed [CW-1:0]   cf [M];
  logic [LV+1:0]          vp;

  always_ff @(posedge clk) begin
    if (clr) begin
      taps <= '0;
    end else if (in_vld) begin
      taps[0] <= in_data;
      for (int i = 1; i < M; i++) taps[i] <= taps[i-1];
    end
  end

  for (genvar k = 0; k < M; k++) begin : g_cf
    assign cf[k] = COEFS[k*CW +: CW];
  end

  for (genvar l = 0; l <= LV; l++) begin : g_lv
    localparam int N = width_at(M, l);
    logic signed [OW-1:0] s [N];

    if (l == 0) begin : g_mul
      always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++)
          s[i] <= clr ? '0 : mulx($signed(taps[i]), cf[i]);
      end
    end else begin : g_add
      localparam int NP = width_at(M, l - 1);
      logic signed [OW-1:0] pad [3*N];
      for (genvar k = 0; k < 3*N; k++) begin : g_pad
        if (k < NP) begin : g_use
          assign pad[k] = g_lv[l-1].s[k];
        end else begin : g_zero
          assign pad[k] = '0;
        end
      end
      always_ff @(posedge clk) begin
        for (int j = 0; j < N; j++)
          s[j] <= clr ? '0 : pad[3*j] + pad[3*j+1] + pad[3*j+2];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (clr) vp <= '0;
    else     vp <= {vp[LV:0], in_vld};
  end

  assign out_vld  = vp[LV+1];
  assign out_data = g_lv[LV].s[0];

endmodule

// File: rtl/tdl_conv_chk.sv
module tdl_conv_chk #(
  parameter int OW  = 21,
  parameter int LAT = 4
) (
  input logic                 clk,
  input logic                 clr,
  input logic                 in_vld,
  input logic                 out_vld,
  input logic signed [OW-1:0] out_data
);

  logic [15:0] since;
  logic [15:0] idle;
  logic        seen;

  always_ff @(posedge clk) begin
    if (clr) begin
      since <= '0;
      idle  <= '0;
      seen  <= 1'b0;
    end else begin
      if (since != 16'hFFFF) since <= since + 16'd1;
      if (in_vld)                 idle <= '0;
      else if (idle != 16'hFFFF)  idle <= idle + 16'd1;
      if (in_vld) seen <= 1'b1;
    end
  end

  // R2
  vld_latency_chk: assert property (@(posedge clk) disable iff (clr)
    (32'(since) >= LAT) |-> (out_vld == $past(in_vld, LAT)));

  // R4
  clear_flush_chk: assert property (@(posedge clk)
    clr |=> (!out_vld && out_data == '0));

  // R4
  zero_history_chk: assert property (@(posedge clk) disable iff (clr)
    !seen |-> (out_data == '0));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (clr)
    (32'(idle) >= LAT && 32'(since) >= LAT) |-> $stable(out_data));

endmodule

bind tdl_conv tdl_conv_chk #(.OW(OW), .LAT(LAT)) u_chk (
  .clk(clk), .clr(clr), .in_vld(in_vld), .out_vld(out_vld), .out_data(out_data));

// File: tb/tb_tdl_conv.sv
module tb_tdl_conv;
  localparam int DW = 10;
  localparam int CW = 8;
  localparam int M  = 7;
  localparam int OW = DW + CW + $clog2(M);
  localparam int C [M] = '{3, -5, 7, -128, 127, 1, -2};

  function automatic logic [M*CW-1:0] pack_coefs();
    logic [M*CW-1:0] p;
    p = '0;
    for (int k = 0; k < M; k++) p[k*CW +: CW] = CW'(C[k]);
    return p;
  endfunction

  function automatic int log3c(input int n);
    int c;
    int l;
    c = 1;
    l = 0;
    while (c < n) begin
      c = c * 3;
      l++;
    end
    return l;
  endfunction

  localparam int LAT = log3c(M) + 2;

  logic                 clk = 1'b0;
  logic                 clr = 1'b1;
  logic                 in_vld = 1'b0;
  logic [DW-1:0]        in_data = '0;
  logic                 out_vld;
  logic signed [OW-1:0] out_data;

  tdl_conv #(.DW(DW), .CW(CW), .M(M), .COEFS(pack_coefs())) dut (
    .clk(clk), .clr(clr), .in_vld(in_vld), .in_data(in_data),
    .out_vld(out_vld), .out_data(out_data));

  always #4 clk = ~clk;

  int     total = 0;
  int     fails = 0;
  int     n = 0;
  int     last_act = 0;
  bit     finished = 0;
  string  tag = "R1";
  longint hist [$];
  bit     exv [0:4095];
  bit     exz [0:4095];
  longint exd [0:4095];
  longint prev_data = 0;

  task automatic chk(input bit ok, input string t, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (edge %0d)", t, act, exp, n);
    end
  endtask

  task automatic check_now();
    longint d;
    d = longint'(out_data);
    if (n < 1) return;
    chk(out_vld == exv[n], "R2", longint'(out_vld), longint'(exv[n]));
    if (exv[n]) chk(d == exd[n], tag, d, exd[n]);
    if (exz[n]) chk(d == 0 && !out_vld, "R4", d, 0);
    if (last_act > 0 && n - last_act >= LAT) chk(d == prev_data, "R7", d, prev_data);
    prev_data = d;
  endtask

  task automatic tick(input bit v, input int d, input bit c);
    int     nx;
    longint s;
    @(negedge clk);
    check_now();
    clr     = c;
    in_vld  = v;
    in_data = DW'(d);
    nx = n + 1;
    if (c) begin
      hist.delete();
      for (int k = nx; k < nx + LAT; k++) exv[k] = 1'b0;
      exz[nx] = 1'b1;
      last_act = nx;
    end else if (v) begin
      hist.push_front(longint'(d));
      if (hist.size() > M) void'(hist.pop_back());
      s = 0;
      for (int k = 0; k < hist.size(); k++) s += longint'(C[k]) * hist[k];
      exv[nx + LAT - 1] = 1'b1;
      exd[nx + LAT - 1] = s;
      last_act = nx;
    end
    n = nx;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", n, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 4096; k++) begin
      exv[k] = 1'b0;
      exz[k] = 1'b0;
      exd[k] = 0;
    end
    // R4: reset state
    repeat (3) tick(0, 0, 1);
    // R6: impulse
    tag = "R6";
    tick(1, 1, 0);
    repeat (9) tick(1, 0, 0);
    repeat (8) tick(0, 0, 0);
    // R1: ramp back to back
    tag = "R1";
    for (int i = 1; i <= 20; i++) tick(1, i, 0);
    // R3: samples with gaps
    tag = "R3";
    for (int i = 0; i < 40; i++) tick((i % 3) != 0, i * 7 - 50, 0);
    repeat (3) tick(0, 0, 0);
    // R5: extreme codes
    tag = "R5";
    repeat (10) tick(1, -512, 0);
    repeat (10) tick(1, 511, 0);
    for (int i = 0; i < 10; i++) tick(1, (i % 2) ? 511 : -512, 0);
    // R4: clear with a full pipeline
    tag = "R4";
    for (int i = 0; i < 5; i++) tick(1, 100 + i, 0);
    tick(0, 0, 1);
    repeat (3) tick(0, 0, 0);
    for (int i = 0; i < 9; i++) tick(1, 30 - i * 9, 0);
    // R7: idle hold
    repeat (12) tick(0, 0, 0);
    tick(0, 0, 0);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule